// File: doc/BRIEF.md
# Branch and Indexed Address Generator

This block works out operand addresses and the next program counter for a small 8-bit processor with a 16-bit address space and an 8-bit index register. The decoder presents the addressing mode, the index register value, the address of the opcode byte, the one or two operand bytes that follow the opcode, and the already-evaluated branch condition, all together with a request strobe.

One clock later the block returns the effective address, the instruction length in bytes, the program counter of the next instruction to fetch, and a single-cycle valid pulse. There are three modes. Two are indexed modes, with an 8-bit or a 16-bit unsigned displacement. The third is a PC-relative branch with a signed 8-bit displacement. For a branch the effective address output carries the branch target, whatever the condition. The next program counter output then selects between that target and the fall-through address. The index register is only read, never returned or altered.

Top module: `addr_gen_core`

## Requirements
- R1: Mode code 0 (short indexed): the effective address is the zero-extended index plus the zero-extended first operand byte, an unsigned sum that stays within 0x0000..0x01FE.
- R2: Mode code 0 reports a length of 2, and its next program counter is the opcode address plus 2, modulo 65536.
- R3: Mode code 1 (long indexed): the effective address is the zero-extended index plus the 16-bit word made of the first operand byte (high) and the second operand byte (low), modulo 65536. The length is 3 and the next program counter is the opcode address plus 3, modulo 65536.
- R4: Mode code 2 (relative branch): the effective address is the opcode address plus 2 plus the first operand byte sign-extended from bit 7, modulo 65536. The length is 2.
- R5: In mode code 2 the next program counter is the branch target when the condition input is 1, and the opcode address plus 2 (modulo 65536) when it is 0.
- R6: The outputs are registered. The valid output is 1 in exactly the cycle after a cycle with the request input at 1. A cycle without a request leaves the effective address, length and next program counter unchanged and drives valid and error to 0.
- R7: Mode code 3 is unsupported. It returns effective address 0, length 1 and next program counter equal to the opcode address plus 1. The error output is 1 together with valid for that one result only.
- R8: While the synchronous active-high reset is 1, all outputs are 0 after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe, one calculation per cycle |
| mode_i | input | 2 | Addressing mode code (0 short indexed, 1 long indexed, 2 relative, 3 unsupported) |
| index_i | input | 8 | Index register value |
| op_addr_i | input | 16 | Address of the opcode byte |
| byte1_i | input | 8 | First byte after the opcode |
| byte2_i | input | 8 | Second byte after the opcode |
| cond_i | input | 1 | Branch condition, 1 = taken |
| valid_o | output | 1 | Result valid pulse |
| ea_o | output | 16 | Effective address or branch target |
| len_o | output | 2 | Instruction length in bytes |
| next_pc_o | output | 16 | Next program counter |
| err_o | output | 1 | Unsupported mode flag |

## Verification
The bench builds the block with its default widths: a 16-bit address, 8-bit bytes and an 8-bit index. With an 8-bit index and 8-bit displacements, every combination of index and short offset can be swept exhaustively. The same holds for every relative displacement under both condition values, at opcode addresses chosen to cross the top and bottom of the address space. The long indexed mode is swept over every index value against displacement words near 0x0000, 0x7FFF and 0xFFFF, which brings the modulo-65536 wrap within reach. Cycles without a request, placed between bursts, show that results hold.

// File: rtl/addrgen_pkg.sv
package addrgen_pkg;

    localparam int AG_ADDR_W = 16;
    localparam int AG_BYTE_W = 8;
    localparam int AG_LEN_W  = 2;

    typedef enum logic [1:0] {
        MODE_IDX_SHORT = 2'd0,
        MODE_IDX_LONG  = 2'd1,
        MODE_REL       = 2'd2,
        MODE_BAD       = 2'd3
    } ag_mode_e;

    typedef struct packed {
        logic [AG_LEN_W-1:0] len;
        logic                is_branch;
        logic                is_long;
        logic                is_err;
    } ag_kind_t;

    function automatic ag_kind_t ag_classify(input ag_mode_e m);
        ag_kind_t k;
        k = '0;
        unique case (m)
            MODE_IDX_SHORT: k.len = AG_LEN_W'(2);
            MODE_IDX_LONG: begin
                k.len     = AG_LEN_W'(3);
                k.is_long = 1'b1;
            end
            MODE_REL: begin
                k.len       = AG_LEN_W'(2);
                k.is_branch = 1'b1;
            end
            default: begin
                k.len    = AG_LEN_W'(1);
                k.is_err = 1'b1;
            end
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ag_index_unit.sv
module ag_index_unit
    import addrgen_pkg::*;
#(
    parameter int ADDR_W = AG_ADDR_W,
    parameter int BYTE_W = AG_BYTE_W
) (
    input  logic [BYTE_W-1:0] index_i,
    input  logic [BYTE_W-1:0] off_hi_i,
    input  logic [BYTE_W-1:0] off_lo_i,
    input  logic              long_i,
    output logic [ADDR_W-1:0] ea_o
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [ADDR_W-1:0] base_idx;
    logic [ADDR_W-1:0] disp;
    logic [WORD_W-1:0] word;

    assign word     = {off_hi_i, off_lo_i};
    assign base_idx = ADDR_W'(index_i);

    always_comb begin
        if (long_i)
            disp = ADDR_W'(word);
        else
            disp = ADDR_W'(off_hi_i);
    end

    assign ea_o = base_idx + disp;

    // R1
    short_range_chk: assert final (long_i || (ea_o <= ADDR_W'(2 * ((1 << BYTE_W) - 1))))
        else $error("short indexed sum out of range");

endmodule

// File: rtl/ag_branch_unit.sv
module ag_branch_unit
    import addrgen_pkg::*;
#(
    parameter int ADDR_W = AG_ADDR_W,
    parameter int BYTE_W = AG_BYTE_W,
    parameter int LEN_W  = AG_LEN_W
) (
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [BYTE_W-1:0] rel_i,
    input  logic              take_i,
    output logic [ADDR_W-1:0] fall_o,
    output logic [ADDR_W-1:0] target_o,
    output logic [ADDR_W-1:0] next_o
);
    localparam int EXT_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] rel_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign rel_ext = {{EXT_W{rel_i[BYTE_W-1]}}, rel_i};
        end else begin : g_noext
            assign rel_ext = rel_i[ADDR_W-1:0];
        end
    endgenerate

    assign fall_o   = op_addr_i + ADDR_W'(len_i);
    assign target_o = fall_o + rel_ext;
    assign next_o   = take_i ? target_o : fall_o;

    // R5
    not_taken_chk: assert final (take_i || (next_o == op_addr_i + ADDR_W'(len_i)))
        else $error("not-taken path must fall through");

endmodule

// File: rtl/ag_out_reg.sv
module ag_out_reg
    import addrgen_pkg::*;
#(
    parameter int ADDR_W = AG_ADDR_W,
    parameter int LEN_W  = AG_LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] next_i,
    input  logic              err_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] next_o,
    output logic              err_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            ea_o    <= '0;
            len_o   <= '0;
            next_o  <= '0;
        end else begin
            valid_o <= load_i;
            err_o   <= load_i & err_i;
            if (load_i) begin
                ea_o   <= ea_i;
                len_o  <= len_i;
                next_o <= next_i;
            end
        end
    end

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(ea_o) && $stable(len_o) && $stable(next_o)));

endmodule

// File: rtl/addr_gen_core.sv
module addr_gen_core
    import addrgen_pkg::*;
#(
    parameter int ADDR_W = AG_ADDR_W,
    parameter int BYTE_W = AG_BYTE_W,
    parameter int LEN_W  = AG_LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic [BYTE_W-1:0] index_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [BYTE_W-1:0] byte1_i,
    input  logic [BYTE_W-1:0] byte2_i,
    input  logic              cond_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              err_o
);
    ag_mode_e          mode;
    ag_kind_t          kind;
    logic [ADDR_W-1:0] idx_ea;
    logic [ADDR_W-1:0] fall_pc;
    logic [ADDR_W-1:0] br_target;
    logic [ADDR_W-1:0] br_next;
    logic [ADDR_W-1:0] ea_sel;
    logic [LEN_W-1:0]  len_sel;

    assign mode    = ag_mode_e'(mode_i);
    assign kind    = ag_classify(mode);
    assign len_sel = LEN_W'(kind.len);

    ag_index_unit #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_index (
        .index_i  (index_i),
        .off_hi_i (byte1_i),
        .off_lo_i (byte2_i),
        .long_i   (kind.is_long),
        .ea_o     (idx_ea)
    );

    ag_branch_unit #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .LEN_W  (LEN_W)
    ) u_branch (
        .op_addr_i (op_addr_i),
        .len_i     (len_sel),
        .rel_i     (byte1_i),
        .take_i    (cond_i & kind.is_branch),
        .fall_o    (fall_pc),
        .target_o  (br_target),
        .next_o    (br_next)
    );

    always_comb begin
        if (kind.is_err)
            ea_sel = '0;
        else if (kind.is_branch)
            ea_sel = br_target;
        else
            ea_sel = idx_ea;
    end

    ag_out_reg #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .load_i  (req_i),
        .ea_i    (ea_sel),
        .len_i   (len_sel),
        .next_i  (br_next),
        .err_i   (kind.is_err),
        .valid_o (valid_o),
        .ea_o    (ea_o),
        .len_o   (len_o),
        .next_o  (next_pc_o),
        .err_o   (err_o)
    );

    // R6
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_i |=> valid_o);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!valid_o && !err_o));

    // R7
    err_result_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (valid_o && ea_o == '0 && len_o == LEN_W'(1)));

    // R2
    short_len_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'd0) |=>
            (len_o == LEN_W'(2) && next_pc_o == ADDR_W'($past(op_addr_i) + ADDR_W'(2))));

    // R3
    long_len_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'd1) |=> (len_o == LEN_W'(3) && !err_o));

    // R5
    taken_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'd2 && cond_i) |=> (next_pc_o == ea_o));

endmodule

// File: tb/tb_addr_gen_core.sv
module tb_addr_gen_core;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_i;
    logic [1:0]  mode_i;
    logic [7:0]  index_i;
    logic [15:0] op_addr_i;
    logic [7:0]  byte1_i;
    logic [7:0]  byte2_i;
    logic        cond_i;
    logic        valid_o;
    logic [15:0] ea_o;
    logic [1:0]  len_o;
    logic [15:0] next_pc_o;
    logic        err_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    addr_gen_core dut (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .mode_i    (mode_i),
        .index_i   (index_i),
        .op_addr_i (op_addr_i),
        .byte1_i   (byte1_i),
        .byte2_i   (byte2_i),
        .cond_i    (cond_i),
        .valid_o   (valid_o),
        .ea_o      (ea_o),
        .len_o     (len_o),
        .next_pc_o (next_pc_o),
        .err_o     (err_o)
    );

    task automatic expect_out(input string tag, input logic v, input logic [15:0] ea,
                              input logic [1:0] ln, input logic [15:0] npc, input logic er);
        checks++;
        if (valid_o !== v || ea_o !== ea || len_o !== ln || next_pc_o !== npc || err_o !== er) begin
            failures++;
            $display("FAIL %s: got v=%0b ea=%h len=%0d npc=%h err=%0b, expected v=%0b ea=%h len=%0d npc=%h err=%0b",
                     tag, valid_o, ea_o, len_o, next_pc_o, err_o, v, ea, ln, npc, er);
        end
    endtask

    // Drive one request at a negedge, check the registered result at the next negedge.
    task automatic run_one(input logic [1:0] m, input logic [7:0] ix, input logic [15:0] op,
                           input logic [7:0] b1, input logic [7:0] b2, input logic c);
        int          ea_i;
        int          ln;
        int          npc;
        logic        er;
        string       tag;
        req_i = 1'b1; mode_i = m; index_i = ix; op_addr_i = op;
        byte1_i = b1; byte2_i = b2; cond_i = c;
        er = 1'b0;
        case (m)
            2'd0: begin
                ea_i = ix + b1; ln = 2; npc = (op + 2) % 65536; tag = "R1/R2";
            end
            2'd1: begin
                ea_i = (ix + b1 * 256 + b2) % 65536; ln = 3; npc = (op + 3) % 65536; tag = "R3";
            end
            2'd2: begin
                ea_i = (op + 2 + ((b1 >= 128) ? (b1 - 256) : b1) + 65536) % 65536;
                ln = 2;
                npc = c ? ea_i : (op + 2) % 65536;
                tag = "R4/R5";
            end
            default: begin
                ea_i = 0; ln = 1; npc = (op + 1) % 65536; er = 1'b1; tag = "R7";
            end
        endcase
        @(negedge clk);
        expect_out(tag, 1'b1, 16'(ea_i), 2'(ln), 16'(npc), er);
    endtask

    // R6: idle cycle with changed inputs keeps the data and drops valid/err.
    task automatic idle_check;
        logic [15:0] ea_h;
        logic [15:0] np_h;
        logic [1:0]  ln_h;
        ea_h = ea_o; np_h = next_pc_o; ln_h = len_o;
        req_i = 1'b0; mode_i = ~mode_i; index_i = ~index_i; op_addr_i = ~op_addr_i;
        byte1_i = ~byte1_i; byte2_i = ~byte2_i; cond_i = ~cond_i;
        @(negedge clk);
        expect_out("R6", 1'b0, ea_h, ln_h, np_h, 1'b0);
    endtask

    initial begin
        rst = 1'b1; req_i = 1'b0; mode_i = 2'd0; index_i = '0; op_addr_i = '0;
        byte1_i = '0; byte2_i = '0; cond_i = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset holds every output at zero even with a request pending
        req_i = 1'b1; mode_i = 2'd3; op_addr_i = 16'h1234;
        @(negedge clk);
        expect_out("R8", 1'b0, 16'h0000, 2'd0, 16'h0000, 1'b0);
        req_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R8", 1'b0, 16'h0000, 2'd0, 16'h0000, 1'b0);

        // R1, R2: exhaustive short indexed sweep
        for (int ix = 0; ix < 256; ix++) begin
            for (int b = 0; b < 256; b++)
                run_one(2'd0, 8'(ix), 16'((ix * 256 + b) ^ 16'hA5C3), 8'(b), 8'(ix ^ b), 1'(b));
        end
        idle_check();

        // R3: every index against edge displacement words, including wrap
        for (int ix = 0; ix < 256; ix++) begin
            for (int k = 0; k < 16; k++) begin
                logic [15:0] w;
                case (k % 4)
                    0: w = 16'(k);
                    1: w = 16'(16'h7FFF - k);
                    2: w = 16'(16'hFFFF - k);
                    default: w = 16'(ix * 251 + k * 4099);
                endcase
                run_one(2'd1, 8'(ix), (k < 8) ? 16'hFFFD : 16'(ix * 3), w[15:8], w[7:0], 1'b0);
            end
        end
        idle_check();

        // R4, R5: every relative offset, both conditions, boundary opcode addresses
        for (int p = 0; p < 6; p++) begin
            logic [15:0] op;
            case (p)
                0: op = 16'h0000;
                1: op = 16'h0005;
                2: op = 16'h7FFE;
                3: op = 16'h8000;
                4: op = 16'hFFFE;
                default: op = 16'hFF80;
            endcase
            for (int b = 0; b < 256; b++) begin
                run_one(2'd2, 8'(b), op, 8'(b), 8'hEE, 1'b1);
                run_one(2'd2, 8'(b), op, 8'(b), 8'h11, 1'b0);
            end
        end
        idle_check();

        // R7: unsupported code, including top-of-memory opcode address
        for (int k = 0; k < 16; k++)
            run_one(2'd3, 8'(k * 17), (k == 0) ? 16'hFFFF : 16'(k * 4111), 8'(k), 8'(~k), 1'(k));
        idle_check();
        // R7: error flag does not linger onto a following valid result
        run_one(2'd3, 8'h01, 16'h0100, 8'h02, 8'h03, 1'b1);
        run_one(2'd0, 8'hFF, 16'h0100, 8'hFF, 8'h00, 1'b0);
        idle_check();
        idle_check();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule